// File: doc/BRIEF.md
# External Memory Port with Wait States and Word Extension

This block is the off-chip memory port of a 16-bit signal-processing core. The core has two request/acknowledge ports, one for program space and one for data space. They share a single 14-bit external address bus and a single 24-bit external data bus. The external data bus is split into an input, an output and an output enable, so it can feed an ordinary bidirectional pad.

Each access asserts one space select, either program or data, and one strobe, either read or write. The strobe is held for a programmable number of extra cycles. The number of extra cycles runs from 0 to 7 and resets to 7, so slow memory works from the start.

Program memory is 24 bits wide, so 16-bit register data moving to or from it passes through an 8-bit extension register:
- On a narrow program write, the extension register supplies the low byte of the word.
- On a narrow program read, the low byte of the fetched word is captured into the extension register.

Data-space transfers use only the upper 16 lines of the data bus.

Top module: `ext_mem_port`

## Requirements
- R1: The address of the access in progress appears on `ext_addr` (14 bits) for both spaces and stays stable while the strobe is active.
- R2: `pms_n` is low during a program-space access and `dms_n` is low during a data-space access. The two are never low together, and both are high when no access is in progress.
- R3: `rd_n` is low during reads and `wr_n` is low during writes, never both at once. `ext_data_oe` is high exactly while `wr_n` is low.
- R4: With a wait setting of N, the select and strobe of an access stay active for N+1 cycles. The port's acknowledge is high only in the last of those cycles.
- R5: The wait setting is 7 after reset. Pulsing `ws_we` loads `ws_din` (3 bits), and the new value applies to accesses that start afterwards.
- R6: A program write with `pm_wide`=1 drives all 24 bits of `pm_wdata`. With `pm_wide`=0 it drives `{pm_wdata[23:8], extension register}`.
- R7: A program read returns the whole 24-bit word on `pm_rdata`. With `pm_wide`=0, bits [7:0] of the word are loaded into the extension register (`px_out`). A wide read leaves the extension register unchanged.
- R8: A data write drives `dm_wdata` on `ext_data_out[23:8]` and zeros on [7:0]. A data read returns `ext_data_in[23:8]` on `dm_rdata`.
- R9: When both ports request in the same idle cycle, the program access is performed first. The data access follows once it completes.
- R10: After every completed access, all strobes and selects are inactive for at least one cycle. A write therefore never starts in the cycle right after a read strobe.
- R11: `px_we` loads `px_din` into the extension register. In a cycle where a narrow program read completes, the fetched byte is loaded and `px_we` is ignored.
- R12: After reset, all selects and strobes are high, `ext_data_oe` and both acknowledges are low, and `px_out` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ws_we | input | 1 | Load the wait setting |
| ws_din | input | 3 | New wait setting |
| px_we | input | 1 | Load the extension register |
| px_din | input | 8 | New extension register value |
| px_out | output | 8 | Extension register value |
| pm_req | input | 1 | Program-space request |
| pm_we | input | 1 | Program request is a write |
| pm_wide | input | 1 | Full 24-bit word (1) or 16-bit data with extension (0) |
| pm_addr | input | 14 | Program address |
| pm_wdata | input | 24 | Program write data (bits 23:8 used when narrow) |
| pm_ack | output | 1 | Program access completes this cycle |
| pm_rdata | output | 24 | Program read data, valid with `pm_ack` |
| dm_req | input | 1 | Data-space request |
| dm_we | input | 1 | Data request is a write |
| dm_addr | input | 14 | Data address |
| dm_wdata | input | 16 | Data write value |
| dm_ack | output | 1 | Data access completes this cycle |
| dm_rdata | output | 16 | Data read value, valid with `dm_ack` |
| ext_addr | output | 14 | External address bus |
| ext_data_in | input | 24 | External data bus, input side |
| ext_data_out | output | 24 | External data bus, output side |
| ext_data_oe | output | 1 | External data bus drive enable |
| pms_n | output | 1 | Program memory select, active low |
| dms_n | output | 1 | Data memory select, active low |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |

## Verification
Random mixes of program and data accesses are tried with several combinations:
- read and write;
- wide and narrow words;
- addresses spanning all 14 bits;
- wait settings changed between accesses.

These mixes separate the four data paths (wide, narrow with the extension byte, data space, and pass-through of the extension byte on a wide read), and they check the strobe length against the setting at each value. Directed cases cover:
- the reset wait setting of 7;
- simultaneous requests from both ports;
- a write right after a read;
- a `px_we` pulse that lands in the completion cycle of a narrow read.

Together these expose a wrong priority, a missing bus gap and a wrong write-versus-fetch order on the extension register.

// File: rtl/ext_mem_port.sv
module ext_mem_port #(
  parameter int AW = 14,
  parameter int DW = 24,
  parameter int RW = 16,
  parameter int WSW = 3,
  parameter int WS_RESET = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ws_we,
  input  logic [WSW-1:0] ws_din,
  input  logic          px_we,
  input  logic [DW-RW-1:0] px_din,
  output logic [DW-RW-1:0] px_out,
  input  logic          pm_req,
  input  logic          pm_we,
  input  logic          pm_wide,
  input  logic [AW-1:0] pm_addr,
  input  logic [DW-1:0] pm_wdata,
  output logic          pm_ack,
  output logic [DW-1:0] pm_rdata,
  input  logic          dm_req,
  input  logic          dm_we,
  input  logic [AW-1:0] dm_addr,
  input  logic [RW-1:0] dm_wdata,
  output logic          dm_ack,
  output logic [RW-1:0] dm_rdata,
  output logic [AW-1:0] ext_addr,
  input  logic [DW-1:0] ext_data_in,
  output logic [DW-1:0] ext_data_out,
  output logic          ext_data_oe,
  output logic          pms_n,
  output logic          dms_n,
  output logic          rd_n,
  output logic          wr_n
);
  localparam int XW = DW - RW;

  logic           busy, sp_pm, a_we, a_wide;
  logic [WSW-1:0] cnt, ws_q;
  logic [AW-1:0]  a_addr;
  logic [DW-1:0]  a_wdata;
  logic [XW-1:0]  px_q;
  logic           done;

  assign done = busy && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      sp_pm   <= 1'b0;
      a_we    <= 1'b0;
      a_wide  <= 1'b0;
      a_addr  <= '0;
      a_wdata <= '0;
      cnt     <= '0;
    end else if (!busy) begin
      if (pm_req || dm_req) begin
        busy   <= 1'b1;
        sp_pm  <= pm_req;
        cnt    <= ws_q;
        a_we   <= pm_req ? pm_we : dm_we;
        a_wide <= pm_req && pm_wide;
        a_addr <= pm_req ? pm_addr : dm_addr;
        if (pm_req)
          a_wdata <= pm_wide ? pm_wdata : {pm_wdata[DW-1:XW], px_q};
        else
          a_wdata <= {dm_wdata, {XW{1'b0}}};
      end
    end else if (done) begin
      busy <= 1'b0;
    end else begin
      cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ws_q <= WSW'(WS_RESET);
    else if (ws_we) ws_q <= ws_din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) px_q <= '0;
    else if (done && sp_pm && !a_we && !a_wide) px_q <= ext_data_in[XW-1:0];
    else if (px_we) px_q <= px_din;
  end

  assign px_out       = px_q;
  assign pm_ack       = done && sp_pm;
  assign dm_ack       = done && !sp_pm;
  assign pm_rdata     = ext_data_in;
  assign dm_rdata     = ext_data_in[DW-1:XW];
  assign ext_addr     = a_addr;
  assign ext_data_out = a_wdata;
  assign ext_data_oe  = busy && a_we;
  assign pms_n        = !(busy && sp_pm);
  assign dms_n        = !(busy && !sp_pm);
  assign rd_n         = !(busy && !a_we);
  assign wr_n         = !(busy && a_we);

  logic [WSW:0] run;
  always_ff @(posedge clk) begin
    if (!rst_n) run <= '0;
    else if (!busy || done) run <= '0;
    else run <= run + 1'b1;
  end

  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n) !(!pms_n && !dms_n)); // R2
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n) !(!rd_n && !wr_n)); // R3
  AST_OE_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n) ext_data_oe == !wr_n); // R3
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n) (!(rd_n && wr_n) && !$past(rd_n && wr_n) && !$past(pm_ack || dm_ack)) |-> $stable(ext_addr)); // R1
  AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({pm_ack, dm_ack})); // R4
  AST_STROBE_LEN: assert property (@(posedge clk) disable iff (!rst_n) run <= (WSW+1)'((1 << WSW) - 1)); // R4
  AST_GAP: assert property (@(posedge clk) disable iff (!rst_n) (pm_ack || dm_ack) |=> (rd_n && wr_n && pms_n && dms_n)); // R10
  AST_TURN: assert property (@(posedge clk) disable iff (!rst_n) $fell(wr_n) |-> $past(rd_n)); // R10
endmodule

// File: tb/tb_ext_mem_port.sv
`timescale 1ns/1ps
module tb_ext_mem_port;
  logic clk = 0, rst_n = 0;
  logic ws_we = 0; logic [2:0] ws_din = 0;
  logic px_we = 0; logic [7:0] px_din = 0; logic [7:0] px_out;
  logic pm_req = 0, pm_we = 0, pm_wide = 0; logic [13:0] pm_addr = 0; logic [23:0] pm_wdata = 0;
  logic pm_ack; logic [23:0] pm_rdata;
  logic dm_req = 0, dm_we = 0; logic [13:0] dm_addr = 0; logic [15:0] dm_wdata = 0;
  logic dm_ack; logic [15:0] dm_rdata;
  logic [13:0] ext_addr; logic [23:0] ext_data_in, ext_data_out;
  logic ext_data_oe, pms_n, dms_n, rd_n, wr_n;

  ext_mem_port dut (.*);

  always #5 clk = ~clk;

  logic [23:0] mem [0:255];
  logic [23:0] mm  [0:255];
  assign ext_data_in = mem[ext_addr[7:0]];
  always @(negedge clk) if (!wr_n) mem[ext_addr[7:0]] <= ext_data_out;

  int n_chk = 0, n_fail = 0;
  logic [2:0] ws_m = 3'd7;
  logic [7:0] px_m = 8'h00;
  bit clash = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] wr_word(input bit pm, input bit wide, input logic [23:0] d, input logic [7:0] px);
    if (!pm) return {d[15:0], 8'h00};
    return wide ? d : {d[23:8], px};
  endfunction

  task automatic set_ws(input logic [2:0] v);
    ws_din = v; ws_we = 1;
    @(negedge clk); ws_we = 0;
    ws_m = v;
  endtask

  task automatic access(input bit pm, input bit we, input bit wide, input logic [13:0] a, input logic [23:0] d);
    int n; bit sel_ok; bit got; logic [23:0] rd; logic [23:0] expw;
    n = 0; sel_ok = 1; got = 0; rd = '0;
    expw = wr_word(pm, wide, d, px_m);
    if (pm) begin pm_req = 1; pm_we = we; pm_wide = wide; pm_addr = a; pm_wdata = d; end
    else begin dm_req = 1; dm_we = we; dm_addr = a; dm_wdata = d[15:0]; end
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (!rd_n || !wr_n) begin
        n++;
        if (pms_n != !pm || dms_n != pm || ext_addr != a || ext_data_oe != we || rd_n != we || wr_n != !we) sel_ok = 0;
      end
      if (pm ? pm_ack : dm_ack) begin
        rd = pm ? pm_rdata : {dm_rdata, 8'h00};
        got = 1;
        pm_req = 0; dm_req = 0;
        if (clash) begin px_we = 1; px_din = 8'h33; end
        break;
      end
    end
    @(negedge clk);
    px_we = 0;
    chk(got, "R4 ack seen", {31'd0, got}, 1);
    chk(n == ws_m + 1, "R4 strobe length", n, ws_m + 1);
    chk(sel_ok, pm ? "R1 R2 R3 program select/strobe" : "R1 R2 R3 data select/strobe", {31'd0, sel_ok}, 1);
    chk(rd_n && wr_n && pms_n && dms_n, "R10 idle gap", {28'd0, rd_n, wr_n, pms_n, dms_n}, 4'hf);
    if (we) begin
      mm[a[7:0]] = expw;
      chk(mem[a[7:0]] == expw, pm ? "R6 program write word" : "R8 data write word", mem[a[7:0]], expw);
    end else begin
      if (pm) begin
        chk(rd == mm[a[7:0]], "R7 program read word", rd, mm[a[7:0]]);
        if (!wide) px_m = mm[a[7:0]][7:0];
      end else begin
        chk(rd[23:8] == mm[a[7:0]][23:8], "R8 data read", rd[23:8], mm[a[7:0]][23:8]);
      end
      chk(px_out == px_m, clash ? "R11 fetch beats px_we" : "R7 extension register", px_out, px_m);
    end
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) begin
      mem[i] = 24'(i * 24'h010203 + 24'h5a0c3);
      mm[i]  = mem[i];
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(pms_n && dms_n && rd_n && wr_n && !ext_data_oe && !pm_ack && !dm_ack, "R12 reset outputs",
        {25'd0, pms_n, dms_n, rd_n, wr_n, ext_data_oe, pm_ack, dm_ack}, 7'b1111000);
    chk(px_out == 8'h00, "R12 extension reset", px_out, 0);

    access(1, 0, 0, 14'h3f05, 0);          // R5 default of 7 wait states
    access(0, 0, 0, 14'h0011, 0);          // R8
    px_din = 8'hA5; px_we = 1; @(negedge clk); px_we = 0; px_m = 8'hA5;
    chk(px_out == 8'hA5, "R11 px_we load", px_out, 8'hA5);
    access(1, 1, 0, 14'h0020, 24'hBEEF00); // R6 narrow write uses extension
    access(1, 1, 1, 14'h0021, 24'h123456); // R6 wide
    access(1, 0, 1, 14'h0021, 0);          // R7 wide read leaves extension
    set_ws(3'd0);
    access(0, 1, 0, 14'h2022, 24'h00C0DE); // R8 write with zero waits
    access(0, 0, 0, 14'h2022, 0);          // R10 then write after read
    access(1, 1, 0, 14'h0030, 24'h777700);
    clash = 1;
    access(1, 0, 0, 14'h0005, 0);          // R11 collision
    clash = 0;
    set_ws(3'd2);

    // R9 simultaneous requests
    pm_req = 1; pm_we = 0; pm_wide = 1; pm_addr = 14'h0040;
    dm_req = 1; dm_we = 0; dm_addr = 14'h0041;
    begin
      bit first_pm; bit first_seen; bit dm_seen;
      first_pm = 0; first_seen = 0; dm_seen = 0;
      for (int i = 0; i < 30; i++) begin
        @(negedge clk);
        if (!first_seen && (pm_ack || dm_ack)) begin
          first_seen = 1; first_pm = pm_ack; pm_req = 0;
        end else if (first_seen && dm_ack) begin
          dm_seen = 1; dm_req = 0; break;
        end
      end
      chk(first_pm, "R9 program first", {31'd0, first_pm}, 1);
      chk(dm_seen, "R9 data served after", {31'd0, dm_seen}, 1);
      @(negedge clk);
    end

    for (int k = 0; k < 300; k++) begin
      if ($urandom_range(0, 9) == 0) set_ws(3'($urandom_range(0, 7)));
      access(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
             14'($urandom), 24'($urandom));
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule